// File: doc/BRIEF.md
# Register and Immediate Instruction Decoder

This block turns one 16-bit instruction word of a small 8-bit core into the control fields that the execute stage needs. It recognises two instruction groups. The first group combines two registers: add, add with carry, subtract, subtract with carry, compare, compare with carry, AND, OR and exclusive OR. The second group combines a register with an 8-bit constant: load constant, subtract constant, AND constant and OR constant. For each word it reports the ALU operation, the destination and second source register numbers, the constant, whether the constant replaces the second register operand, whether the result is written back, whether the status flags are updated, and whether the word is unknown or a no-op.

Two sub-decoders work in parallel, one for each group. A merge stage picks the group that matched. If neither group matched, the merge stage emits a quiet no-op. The parameter `OUT_REG` selects whether the merged result passes through an output register, which adds one cycle, or goes straight to the ports.

Top module: `insn_decoder`

## Requirements
- R1: With `OUT_REG`=1, the outputs show the decode of the word sampled at the previous rising clock edge. While `rst` is high at an edge, every output is cleared to zero.
- R2: The ALU op encoding is PASS=0, ADD=1, ADC=2, SUB=3, SBC=4, AND=5, OR=6, XOR=7. Word bits 15:10 select the register-register operation: 000011 ADD, 000111 ADC, 000110 SUB, 000010 SBC, 000101 CP (op SUB), 000001 CPC (op SBC), 001000 AND, 001010 OR.
- R3: For a register-register word, the destination `rd_o` is bits 8:4 and the second source `rs_o` is {bit 9, bits 3:0}. In these words `use_imm_o`=0 and `imm_o`=0. Both fields may name the same register.
- R4: Every register-register operation except CP and CPC sets `wb_en_o`=1 and `flag_en_o`=1, so the result goes back to the register that feeds the first ALU input.
- R5: CP and CPC set `flag_en_o`=1 and `wb_en_o`=0.
- R6: Word bits 15:12 select the immediate form: 1110 load constant, 0101 subtract constant (op SUB), 0110 OR constant (op OR), 0111 AND constant (op AND). In these words `rd_o` = 16 + bits 7:4, `imm_o` = {bits 11:8, bits 3:0}, `use_imm_o`=1 and `rs_o`=0.
- R7: Load constant sets op PASS with `wb_en_o`=1 and `flag_en_o`=0. The other three immediate forms set `wb_en_o`=1 and `flag_en_o`=1.
- R8: Word bits 15:10 equal to 001001 decode to op XOR as a register-register form with write-back and flag update.
- R9: The word 0xFFFF and any encoding not listed above set `bad_o`=1, with `wb_en_o`=0, `flag_en_o`=0, op PASS, and `rd_o`, `rs_o`, `imm_o` and `use_imm_o` all zero. Every recognised word sets `bad_o`=0.
- R10: With `OUT_REG`=0, the outputs follow `insn_i` in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 16 | Instruction word |
| alu_op_o | output | 3 | ALU operation code |
| rd_o | output | 5 | Destination and first source register |
| rs_o | output | 5 | Second source register |
| imm_o | output | 8 | Immediate constant |
| use_imm_o | output | 1 | Constant replaces the second operand |
| wb_en_o | output | 1 | Result is written back |
| flag_en_o | output | 1 | Status flags are updated |
| bad_o | output | 1 | Unknown word or no-op |

## Verification
The bench builds two instances side by side. One uses `OUT_REG`=1 and is sampled one edge after each word is applied. The other uses `OUT_REG`=0 and is sampled in the same cycle, before any edge. Applying every word to both instances checks the registered timing and the reset clearing of the first, and shows that the combinational variant decodes identically with zero latency. Field patterns cover the register-number boundaries: the same register in both fields, register 0 against register 31, and immediate registers 16 and 31.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int WORD_W = 16;
  localparam int REG_AW = 5;
  localparam int IMM_W  = 8;
  localparam int RR_OPC_W  = 6;
  localparam int IMM_OPC_W = 4;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADC  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SBC  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } alu_op_e;

  typedef struct packed {
    alu_op_e            op;
    logic [REG_AW-1:0]  rd;
    logic [REG_AW-1:0]  rs;
    logic [IMM_W-1:0]   imm;
    logic               use_imm;
    logic               wb;
    logic               flg;
    logic               bad;
  } dec_t;

  // register-register opcodes, word bits 15:10
  localparam logic [RR_OPC_W-1:0] RR_ADD = 6'b000011;
  localparam logic [RR_OPC_W-1:0] RR_ADC = 6'b000111;
  localparam logic [RR_OPC_W-1:0] RR_SUB = 6'b000110;
  localparam logic [RR_OPC_W-1:0] RR_SBC = 6'b000010;
  localparam logic [RR_OPC_W-1:0] RR_CMP = 6'b000101;
  localparam logic [RR_OPC_W-1:0] RR_CMC = 6'b000001;
  localparam logic [RR_OPC_W-1:0] RR_AND = 6'b001000;
  localparam logic [RR_OPC_W-1:0] RR_OR  = 6'b001010;
  localparam logic [RR_OPC_W-1:0] RR_XOR = 6'b001001;

  // register-constant opcodes, word bits 15:12
  localparam logic [IMM_OPC_W-1:0] IM_LOAD = 4'b1110;
  localparam logic [IMM_OPC_W-1:0] IM_SUB  = 4'b0101;
  localparam logic [IMM_OPC_W-1:0] IM_OR   = 4'b0110;
  localparam logic [IMM_OPC_W-1:0] IM_AND  = 4'b0111;
endpackage

// File: rtl/rr_group_dec.sv
module rr_group_dec
  import insn_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o,
  output dec_t              dec_o
);
  localparam int OPC_LSB = WORD_W - RR_OPC_W;

  logic [RR_OPC_W-1:0] opc;
  assign opc = word_i[WORD_W-1:OPC_LSB];

  always_comb begin
    dec_o         = '0;
    hit_o         = 1'b1;
    dec_o.rd      = word_i[8:4];
    dec_o.rs      = {word_i[9], word_i[3:0]};
    dec_o.wb      = 1'b1;
    dec_o.flg     = 1'b1;
    unique case (opc)
      RR_ADD: dec_o.op = OP_ADD;
      RR_ADC: dec_o.op = OP_ADC;
      RR_SUB: dec_o.op = OP_SUB;
      RR_SBC: dec_o.op = OP_SBC;
      RR_CMP: begin dec_o.op = OP_SUB; dec_o.wb = 1'b0; end
      RR_CMC: begin dec_o.op = OP_SBC; dec_o.wb = 1'b0; end
      RR_AND: dec_o.op = OP_AND;
      RR_OR:  dec_o.op = OP_OR;
      RR_XOR: dec_o.op = OP_XOR;
      default: begin
        hit_o = 1'b0;
        dec_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/imm_group_dec.sv
module imm_group_dec
  import insn_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o,
  output dec_t              dec_o
);
  localparam int OPC_LSB  = WORD_W - IMM_OPC_W;
  localparam int HALF_IMM = IMM_W / 2;
  localparam int FLD_W    = REG_AW - 1;

  logic [IMM_OPC_W-1:0] opc;
  logic [FLD_W-1:0]     rfield;
  assign opc    = word_i[WORD_W-1:OPC_LSB];
  assign rfield = word_i[HALF_IMM+FLD_W-1:HALF_IMM];

  always_comb begin
    dec_o         = '0;
    hit_o         = 1'b1;
    dec_o.rd      = {1'b1, rfield};
    dec_o.imm     = {word_i[OPC_LSB-1:OPC_LSB-HALF_IMM], word_i[HALF_IMM-1:0]};
    dec_o.use_imm = 1'b1;
    dec_o.wb      = 1'b1;
    dec_o.flg     = 1'b1;
    unique case (opc)
      IM_LOAD: begin dec_o.op = OP_PASS; dec_o.flg = 1'b0; end
      IM_SUB:  dec_o.op = OP_SUB;
      IM_OR:   dec_o.op = OP_OR;
      IM_AND:  dec_o.op = OP_AND;
      default: begin
        hit_o = 1'b0;
        dec_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/dec_merge.sv
module dec_merge
  import insn_dec_pkg::*;
(
  input  logic rr_hit_i,
  input  dec_t rr_dec_i,
  input  logic im_hit_i,
  input  dec_t im_dec_i,
  output dec_t dec_o
);
  always_comb begin
    if (rr_hit_i)      dec_o = rr_dec_i;
    else if (im_hit_i) dec_o = im_dec_i;
    else begin
      dec_o     = '0;
      dec_o.bad = 1'b1;
    end
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WORD_W-1:0]       insn_i,
  output logic [2:0]              alu_op_o,
  output logic [REG_AW-1:0]       rd_o,
  output logic [REG_AW-1:0]       rs_o,
  output logic [IMM_W-1:0]        imm_o,
  output logic                    use_imm_o,
  output logic                    wb_en_o,
  output logic                    flag_en_o,
  output logic                    bad_o
);
  logic rr_hit, im_hit;
  dec_t rr_dec, im_dec, mrg, q;

  rr_group_dec  u_rr  (.word_i(insn_i), .hit_o(rr_hit), .dec_o(rr_dec));
  imm_group_dec u_imm (.word_i(insn_i), .hit_o(im_hit), .dec_o(im_dec));
  dec_merge     u_mrg (.rr_hit_i(rr_hit), .rr_dec_i(rr_dec),
                       .im_hit_i(im_hit), .im_dec_i(im_dec), .dec_o(mrg));

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= mrg;
      end
    end else begin : g_comb
      assign q = mrg;
    end
  endgenerate

  assign alu_op_o  = q.op;
  assign rd_o      = q.rd;
  assign rs_o      = q.rs;
  assign imm_o     = q.imm;
  assign use_imm_o = q.use_imm;
  assign wb_en_o   = q.wb;
  assign flag_en_o = q.flg;
  assign bad_o     = q.bad;

  // the two group decoders never claim the same word (R9 priority)
  a_r9_groups_disjoint: assert property (@(posedge clk) disable iff (rst)
    !(rr_hit && im_hit));
  // unknown words stay quiet
  a_r9_bad_quiet: assert property (@(posedge clk) disable iff (rst)
    bad_o |-> (!wb_en_o && !flag_en_o && !use_imm_o));
  // constant forms always address the upper register half
  a_r6_imm_upper: assert property (@(posedge clk) disable iff (rst)
    use_imm_o |-> rd_o[REG_AW-1]);
  // flag update without write-back only for compares
  a_r5_cmp_no_wb: assert property (@(posedge clk) disable iff (rst)
    (flag_en_o && !wb_en_o) |->
      (alu_op_o == OP_SUB || alu_op_o == OP_SBC) && !use_imm_o);
  // write-back without flags only for load constant
  a_r7_load_no_flags: assert property (@(posedge clk) disable iff (rst)
    (wb_en_o && !flag_en_o) |-> (alu_op_o == OP_PASS && use_imm_o));
endmodule

// File: tb/insn_decoder_bench.sv
module insn_decoder_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] insn = 16'h0000;

  logic [2:0] op_r, op_c;
  logic [4:0] rd_r, rd_c, rs_r, rs_c;
  logic [7:0] im_r, im_c;
  logic ui_r, ui_c, wb_r, wb_c, fl_r, fl_c, bd_r, bd_c;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_decoder #(.OUT_REG(1'b1)) u_insn_decoder (
    .clk(clk), .rst(rst), .insn_i(insn), .alu_op_o(op_r), .rd_o(rd_r),
    .rs_o(rs_r), .imm_o(im_r), .use_imm_o(ui_r), .wb_en_o(wb_r),
    .flag_en_o(fl_r), .bad_o(bd_r));

  insn_decoder #(.OUT_REG(1'b0)) u_insn_decoder_comb (
    .clk(clk), .rst(rst), .insn_i(insn), .alu_op_o(op_c), .rd_o(rd_c),
    .rs_o(rs_c), .imm_o(im_c), .use_imm_o(ui_c), .wb_en_o(wb_c),
    .flag_en_o(fl_c), .bad_o(bd_c));

  // expected vector layout: {op3, rd5, rs5, imm8, use_imm, wb, flg, bad}
  function automatic logic [24:0] ex(input logic [2:0] op, input logic [4:0] rd,
      input logic [4:0] rs, input logic [7:0] k, input logic ui,
      input logic wb, input logic fl, input logic bd);
    return {op, rd, rs, k, ui, wb, fl, bd};
  endfunction

  function automatic logic [15:0] rr_word(input logic [5:0] opc,
      input logic [4:0] rd, input logic [4:0] rs);
    return {opc, rs[4], rd, rs[3:0]};
  endfunction

  function automatic logic [15:0] im_word(input logic [3:0] opc,
      input logic [3:0] r, input logic [7:0] k);
    return {opc, k[7:4], r, k[3:0]};
  endfunction

  task automatic cmp(input string tag, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s insn=%h actual=%h expected=%h", tag, insn, act, exp);
    end
  endtask

  // apply at falling edge; combinational copy checked before the next edge (R10),
  // registered copy checked after that edge (R1)
  task automatic apply(input string tag, input logic [15:0] w, input logic [24:0] exp);
    @(negedge clk);
    insn = w;
    #1;
    cmp({tag, " R10 comb"}, {op_c, rd_c, rs_c, im_c, ui_c, wb_c, fl_c, bd_c}, exp);
    @(posedge clk);
    #1;
    cmp({tag, " R1 reg"}, {op_r, rd_r, rs_r, im_r, ui_r, wb_r, fl_r, bd_r}, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    insn = rr_word(6'b000011, 5'd3, 5'd4);
    @(posedge clk); #1;
    cmp("R1 reset clears", {op_r, rd_r, rs_r, im_r, ui_r, wb_r, fl_r, bd_r}, 25'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_rr_ops;
    // R2 R4: each operation code, rd=5 rs=18
    apply("R2 R4 add", rr_word(6'b000011, 5'd5, 5'd18), ex(3'd1, 5'd5, 5'd18, 8'd0, 0, 1, 1, 0));
    apply("R2 R4 adc", rr_word(6'b000111, 5'd5, 5'd18), ex(3'd2, 5'd5, 5'd18, 8'd0, 0, 1, 1, 0));
    apply("R2 R4 sub", rr_word(6'b000110, 5'd5, 5'd18), ex(3'd3, 5'd5, 5'd18, 8'd0, 0, 1, 1, 0));
    apply("R2 R4 sbc", rr_word(6'b000010, 5'd5, 5'd18), ex(3'd4, 5'd5, 5'd18, 8'd0, 0, 1, 1, 0));
    apply("R2 R4 and", rr_word(6'b001000, 5'd5, 5'd18), ex(3'd5, 5'd5, 5'd18, 8'd0, 0, 1, 1, 0));
    apply("R2 R4 or",  rr_word(6'b001010, 5'd5, 5'd18), ex(3'd6, 5'd5, 5'd18, 8'd0, 0, 1, 1, 0));
  endtask

  task automatic t_rr_fields;
    apply("R3 same reg", rr_word(6'b000111, 5'd9, 5'd9),  ex(3'd2, 5'd9, 5'd9, 8'd0, 0, 1, 1, 0));
    apply("R3 r0 r31",   rr_word(6'b000011, 5'd0, 5'd31), ex(3'd1, 5'd0, 5'd31, 8'd0, 0, 1, 1, 0));
    apply("R3 r31 r0",   rr_word(6'b001000, 5'd31, 5'd0), ex(3'd5, 5'd31, 5'd0, 8'd0, 0, 1, 1, 0));
    apply("R3 r16 r15",  rr_word(6'b000110, 5'd16, 5'd15), ex(3'd3, 5'd16, 5'd15, 8'd0, 0, 1, 1, 0));
  endtask

  task automatic t_compare;
    apply("R5 cp",  rr_word(6'b000101, 5'd7, 5'd20), ex(3'd3, 5'd7, 5'd20, 8'd0, 0, 0, 1, 0));
    apply("R5 cpc", rr_word(6'b000001, 5'd30, 5'd1), ex(3'd4, 5'd30, 5'd1, 8'd0, 0, 0, 1, 0));
  endtask

  task automatic t_imm;
    apply("R6 R7 subi", im_word(4'b0101, 4'd0, 8'hA5),  ex(3'd3, 5'd16, 5'd0, 8'hA5, 1, 1, 1, 0));
    apply("R6 R7 ori",  im_word(4'b0110, 4'd15, 8'h3C), ex(3'd6, 5'd31, 5'd0, 8'h3C, 1, 1, 1, 0));
    apply("R6 R7 andi", im_word(4'b0111, 4'd6, 8'h0F),  ex(3'd5, 5'd22, 5'd0, 8'h0F, 1, 1, 1, 0));
  endtask

  task automatic t_load;
    apply("R7 ldi 55", im_word(4'b1110, 4'd0, 8'h55), ex(3'd0, 5'd16, 5'd0, 8'h55, 1, 1, 0, 0));
    apply("R7 ldi FF", im_word(4'b1110, 4'd15, 8'hFF), ex(3'd0, 5'd31, 5'd0, 8'hFF, 1, 1, 0, 0));
    apply("R7 ldi 00", im_word(4'b1110, 4'd1, 8'h00), ex(3'd0, 5'd17, 5'd0, 8'h00, 1, 1, 0, 0));
  endtask

  task automatic t_xor;
    apply("R8 xor", rr_word(6'b001001, 5'd12, 5'd12), ex(3'd7, 5'd12, 5'd12, 8'd0, 0, 1, 1, 0));
    apply("R8 xor2", rr_word(6'b001001, 5'd2, 5'd27), ex(3'd7, 5'd2, 5'd27, 8'd0, 0, 1, 1, 0));
  endtask

  task automatic t_illegal;
    apply("R9 FFFF", 16'hFFFF, ex(3'd0, 5'd0, 5'd0, 8'd0, 0, 0, 0, 1));
    apply("R9 0000", 16'h0000, ex(3'd0, 5'd0, 5'd0, 8'd0, 0, 0, 0, 1));
    apply("R9 top 001011", rr_word(6'b001011, 5'd3, 5'd3), ex(3'd0, 5'd0, 5'd0, 8'd0, 0, 0, 0, 1));
    apply("R9 top 1111", 16'hF123, ex(3'd0, 5'd0, 5'd0, 8'd0, 0, 0, 0, 1));
    apply("R9 top 1000", 16'h8A5C, ex(3'd0, 5'd0, 5'd0, 8'd0, 0, 0, 0, 1));
    // recognised word right after an unknown one: no leftover bad flag
    apply("R9 recover", rr_word(6'b000011, 5'd1, 5'd2), ex(3'd1, 5'd1, 5'd2, 8'd0, 0, 1, 1, 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_rr_ops();
    t_rr_fields();
    t_compare();
    t_imm();
    t_load();
    t_xor();
    t_illegal();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule